// File: doc/BRIEF.md
# Unified Translation Buffer with Pinned Region

This block caches virtual-to-physical page translations for a processor core. One lookup port serves instruction fetches and data accesses alike. A lookup presents a virtual page number and gets back, one cycle later, a hit flag, a physical page number and a permission field. Entries come from a page-walk unit through a write port.

Storage is split in two. A pinned region of eight fully-associative slots holds entries that software wants kept. A two-way, 32-set region holds everything else. The set is indexed by the low five bits of the virtual page number, and replacement within a set is round-robin. At the moment of each write, a pin flag and a 3-bit slot number pick the region: with the flag set, the entry goes into the named pinned slot. The clear-everything command empties only the set-associative region. The clear-by-address command removes matching entries from both regions. With translation switched off, every lookup returns its own page number unchanged, and the stored contents are kept.

The response path is a small state machine with four states. `RSP_IDLE` means no lookup was presented. `RSP_FLAT` means translation was off. `RSP_HIT` means an entry matched. `RSP_MISS` means nothing matched. At every clock edge the machine moves from whatever state it holds to the state chosen by that cycle's lookup: to `RSP_IDLE` when `lk_vld` is low, to `RSP_FLAT` when `xlat_en` is low, to `RSP_HIT` when either region matches, and to `RSP_MISS` otherwise. Reset forces `RSP_IDLE`.

Top module: `tlb_unified`

## Requirements
- R1: After reset every entry in both regions is invalid, so a lookup with translation enabled returns a miss (`rsp_hit`=0, `rsp_ppn`=0, `rsp_perm`=0).
- R2: With `xlat_en` low, a lookup returns `rsp_hit`=1, `rsp_ppn` equal to the looked-up page number, and `rsp_perm` all ones, whatever the buffer holds.
- R3: `rsp_vld` is high in exactly the cycle after a cycle with `lk_vld` high, and low otherwise.
- R4: A write with `wr_pin`=0 places the entry in the set-associative region, at set `wr_vpn[4:0]`. From the next cycle on, a lookup of that page hits and returns the written page number and permissions.
- R5: A write with `wr_pin`=1 places the entry in pinned slot `wr_slot`, and later lookups of that page hit.
- R6: When a page matches in both regions, the response carries the pinned entry's data. Among several matching pinned slots, the lowest-numbered slot wins.
- R7: `inv_all` clears every set-associative entry and leaves all pinned entries valid.
- R8: `inv_va` clears, in one cycle, every valid entry in both regions whose page equals `inv_vpn`. Other entries are left untouched.
- R9: Writing a pinned slot replaces its previous entry, so the old page then misses.
- R10: Each set has its own replacement pointer. Every write of a page not already present in the set uses the way the pointer names and then advances the pointer, so a third distinct page in a set evicts the first.
- R11: Writing a page that is already present in its set overwrites that way in place and does not advance the set's pointer.
- R12: Switching translation off and back on leaves all entries in place.
- R13: A write in the same cycle as `inv_all` or `inv_va` takes effect after the clear, so the written entry survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlat_en | input | 1 | Translation on (1) or flat mapping (0) |
| lk_vld | input | 1 | Lookup request |
| lk_vpn | input | 20 | Virtual page number to look up |
| rsp_vld | output | 1 | Response valid, one cycle after the request |
| rsp_hit | output | 1 | Translation found, or flat mapping |
| rsp_ppn | output | 20 | Physical page number, zero on a miss |
| rsp_perm | output | 4 | Permission field, zero on a miss, all ones when flat |
| wr_en | input | 1 | Write a translation |
| wr_vpn | input | 20 | Virtual page number of the write |
| wr_ppn | input | 20 | Physical page number of the write |
| wr_perm | input | 4 | Permissions of the write |
| wr_pin | input | 1 | Steer the write into the pinned region |
| wr_slot | input | 3 | Pinned slot to write when `wr_pin` is 1 |
| inv_all | input | 1 | Clear the whole set-associative region |
| inv_va | input | 1 | Clear entries matching `inv_vpn` in both regions |
| inv_vpn | input | 20 | Page number for `inv_va` |

## Verification
The bench fills one set with three distinct pages and then rewrites a page already present. It follows that with a fourth page, so a pointer that advanced on the rewrite would evict a different way than one that held still. It loads the same page into both regions to show which one the response draws from. It clears after mixed pinned and unpinned fills to tell the whole-region clear apart from the address clear. Lookups run with translation both on and off against the same contents, which separates flat mapping from lost entries. A write issued together with a clear shows the ordering between the two.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    // Response state of the lookup pipeline stage
    typedef enum logic [1:0] {
        RSP_IDLE = 2'd0,
        RSP_FLAT = 2'd1,
        RSP_HIT  = 2'd2,
        RSP_MISS = 2'd3
    } rsp_state_e;

endpackage

// File: rtl/tlb_pin_cam.sv
module tlb_pin_cam #(
    parameter int VPN_W  = 20,
    parameter int PN_W   = 20,
    parameter int PERM_W = 4,
    parameter int SLOTS  = 8,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              hit,
    output logic [PN_W-1:0]   ppn,
    output logic [PERM_W-1:0] perm,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PN_W-1:0]   wr_ppn,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic              inv_va,
    input  logic [VPN_W-1:0]  inv_vpn
);

    logic [SLOTS-1:0]  vld_vec;
    logic [SLOTS-1:0]  match_vec;
    logic [VPN_W-1:0]  vpn_arr  [SLOTS];
    logic [PN_W-1:0]   ppn_arr  [SLOTS];
    logic [PERM_W-1:0] perm_arr [SLOTS];

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic              v_q;
        logic [VPN_W-1:0]  vpn_q;
        logic [PN_W-1:0]   ppn_q;
        logic [PERM_W-1:0] perm_q;
        logic              sel;
        logic              kill;

        assign sel  = wr_en && (wr_slot == SLOT_W'(i));
        assign kill = inv_va && v_q && (vpn_q == inv_vpn);

        // write applied after the clear: a selected slot always ends valid
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
            end else if (sel) begin
                v_q <= 1'b1;
            end else if (kill) begin
                v_q <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                vpn_q  <= wr_vpn;
                ppn_q  <= wr_ppn;
                perm_q <= wr_perm;
            end
        end

        assign vld_vec[i]   = v_q;
        assign match_vec[i] = v_q && (vpn_q == lk_vpn);
        assign vpn_arr[i]   = vpn_q;
        assign ppn_arr[i]   = ppn_q;
        assign perm_arr[i]  = perm_q;
    end

    // lowest matching slot wins
    always_comb begin
        hit  = 1'b0;
        ppn  = '0;
        perm = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit  = 1'b1;
                ppn  = ppn_arr[i];
                perm = perm_arr[i];
            end
        end
    end

    // R7
    pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !inv_va) |=> $stable(vld_vec));

    // R5
    pin_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (vld_vec[$past(wr_slot)] && vpn_arr[$past(wr_slot)] == $past(wr_vpn)));

endmodule

// File: rtl/tlb_set_ram.sv
module tlb_set_ram #(
    parameter int VPN_W  = 20,
    parameter int PN_W   = 20,
    parameter int PERM_W = 4,
    parameter int SETS   = 32,
    parameter int WAYS   = 2,
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = VPN_W - IDX_W,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              hit,
    output logic [PN_W-1:0]   ppn,
    output logic [PERM_W-1:0] perm,
    input  logic              wr_en,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [PN_W-1:0]   wr_ppn,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic              inv_all,
    input  logic              inv_va,
    input  logic [VPN_W-1:0]  inv_vpn
);

    logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
    logic [PN_W-1:0]   ppn_q  [SETS][WAYS];
    logic [PERM_W-1:0] perm_q [SETS][WAYS];
    logic [WAYS-1:0]   vld_q  [SETS];
    logic [WAY_W-1:0]  ptr_q  [SETS];

    logic [IDX_W-1:0] lk_idx, wr_idx, inv_idx;
    logic [TAG_W-1:0] lk_tag, wr_tag, inv_tag;

    assign lk_idx  = lk_vpn[IDX_W-1:0];
    assign lk_tag  = lk_vpn[VPN_W-1:IDX_W];
    assign wr_idx  = wr_vpn[IDX_W-1:0];
    assign wr_tag  = wr_vpn[VPN_W-1:IDX_W];
    assign inv_idx = inv_vpn[IDX_W-1:0];
    assign inv_tag = inv_vpn[VPN_W-1:IDX_W];

    logic [WAYS-1:0] lk_match;
    logic [WAYS-1:0] wr_match;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign lk_match[w] = vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
        assign wr_match[w] = vld_q[wr_idx][w] && (tag_q[wr_idx][w] == wr_tag);
    end

    // lookup read, lowest way wins
    always_comb begin
        hit  = 1'b0;
        ppn  = '0;
        perm = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (lk_match[w]) begin
                hit  = 1'b1;
                ppn  = ppn_q[lk_idx][w];
                perm = perm_q[lk_idx][w];
            end
        end
    end

    // victim: the way already holding the page, else the pointer's way
    logic             wr_rehit;
    logic [WAY_W-1:0] rehit_way;
    logic [WAY_W-1:0] victim;

    always_comb begin
        wr_rehit  = 1'b0;
        rehit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (wr_match[w]) begin
                wr_rehit  = 1'b1;
                rehit_way = WAY_W'(w);
            end
        end
        victim = wr_rehit ? rehit_way : ptr_q[wr_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                ptr_q[s] <= '0;
            end
        end else begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (wr_en && wr_idx == IDX_W'(s) && victim == WAY_W'(w)) begin
                        vld_q[s][w] <= 1'b1;
                    end else if (inv_all ||
                                 (inv_va && inv_idx == IDX_W'(s) && tag_q[s][w] == inv_tag)) begin
                        vld_q[s][w] <= 1'b0;
                    end
                end
            end
            if (wr_en && !wr_rehit) begin
                ptr_q[wr_idx] <= ptr_q[wr_idx] + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx][victim]  <= wr_tag;
            ppn_q[wr_idx][victim]  <= wr_ppn;
            perm_q[wr_idx][victim] <= wr_perm;
        end
    end

    // R4
    set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (|vld_q[$past(wr_idx)]));

    // R7
    set_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all && !wr_en) |=> !(|vld_q[lk_idx]));

endmodule

// File: rtl/tlb_rsp_fsm.sv
module tlb_rsp_fsm
    import tlb_pkg::*;
#(
    parameter int PN_W   = 20,
    parameter int PERM_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_vld,
    input  logic              xlat_en,
    input  logic [PN_W-1:0]   lk_vpn,
    input  logic              pin_hit,
    input  logic [PN_W-1:0]   pin_ppn,
    input  logic [PERM_W-1:0] pin_perm,
    input  logic              set_hit,
    input  logic [PN_W-1:0]   set_ppn,
    input  logic [PERM_W-1:0] set_perm,
    output logic              rsp_vld,
    output logic              rsp_hit,
    output logic [PN_W-1:0]   rsp_ppn,
    output logic [PERM_W-1:0] rsp_perm
);

    rsp_state_e state_q, state_d;
    logic [PN_W-1:0]   pn_q;
    logic [PERM_W-1:0] perm_q;

    always_comb begin
        if (!lk_vld) begin
            state_d = RSP_IDLE;
        end else if (!xlat_en) begin
            state_d = RSP_FLAT;
        end else if (pin_hit || set_hit) begin
            state_d = RSP_HIT;
        end else begin
            state_d = RSP_MISS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // captured data: own page when flat, pinned data ahead of set data
    always_ff @(posedge clk) begin
        if (lk_vld) begin
            if (!xlat_en) begin
                pn_q   <= lk_vpn;
                perm_q <= '1;
            end else if (pin_hit) begin
                pn_q   <= pin_ppn;
                perm_q <= pin_perm;
            end else begin
                pn_q   <= set_ppn;
                perm_q <= set_perm;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            RSP_IDLE: begin
                rsp_vld = 1'b0; rsp_hit = 1'b0; rsp_ppn = '0; rsp_perm = '0;
            end
            RSP_FLAT, RSP_HIT: begin
                rsp_vld = 1'b1; rsp_hit = 1'b1; rsp_ppn = pn_q; rsp_perm = perm_q;
            end
            RSP_MISS: begin
                rsp_vld = 1'b1; rsp_hit = 1'b0; rsp_ppn = '0; rsp_perm = '0;
            end
            default: begin
                rsp_vld = 1'b0; rsp_hit = 1'b0; rsp_ppn = '0; rsp_perm = '0;
            end
        endcase
    end

    // R3
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_vld |=> rsp_vld);

    // R3
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_vld |=> !rsp_vld);

endmodule

// File: rtl/tlb_unified.sv
module tlb_unified #(
    parameter int PN_W   = 20,
    parameter int PERM_W = 4,
    parameter int SETS   = 32,
    parameter int WAYS   = 2,
    parameter int SLOTS  = 8,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xlat_en,
    input  logic              lk_vld,
    input  logic [PN_W-1:0]   lk_vpn,
    output logic              rsp_vld,
    output logic              rsp_hit,
    output logic [PN_W-1:0]   rsp_ppn,
    output logic [PERM_W-1:0] rsp_perm,
    input  logic              wr_en,
    input  logic [PN_W-1:0]   wr_vpn,
    input  logic [PN_W-1:0]   wr_ppn,
    input  logic [PERM_W-1:0] wr_perm,
    input  logic              wr_pin,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              inv_all,
    input  logic              inv_va,
    input  logic [PN_W-1:0]   inv_vpn
);

    logic              pin_hit, set_hit;
    logic [PN_W-1:0]   pin_ppn, set_ppn;
    logic [PERM_W-1:0] pin_perm, set_perm;
    logic              pin_wr, set_wr;

    assign pin_wr = wr_en && wr_pin;
    assign set_wr = wr_en && !wr_pin;

    tlb_pin_cam #(
        .VPN_W(PN_W), .PN_W(PN_W), .PERM_W(PERM_W), .SLOTS(SLOTS)
    ) u_pin (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(lk_vpn), .hit(pin_hit), .ppn(pin_ppn), .perm(pin_perm),
        .wr_en(pin_wr), .wr_slot(wr_slot), .wr_vpn(wr_vpn),
        .wr_ppn(wr_ppn), .wr_perm(wr_perm),
        .inv_va(inv_va), .inv_vpn(inv_vpn)
    );

    tlb_set_ram #(
        .VPN_W(PN_W), .PN_W(PN_W), .PERM_W(PERM_W), .SETS(SETS), .WAYS(WAYS)
    ) u_set (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(lk_vpn), .hit(set_hit), .ppn(set_ppn), .perm(set_perm),
        .wr_en(set_wr), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .wr_perm(wr_perm),
        .inv_all(inv_all), .inv_va(inv_va), .inv_vpn(inv_vpn)
    );

    tlb_rsp_fsm #(
        .PN_W(PN_W), .PERM_W(PERM_W)
    ) u_rsp (
        .clk(clk), .rst_n(rst_n),
        .lk_vld(lk_vld), .xlat_en(xlat_en), .lk_vpn(lk_vpn),
        .pin_hit(pin_hit), .pin_ppn(pin_ppn), .pin_perm(pin_perm),
        .set_hit(set_hit), .set_ppn(set_ppn), .set_perm(set_perm),
        .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .rsp_perm(rsp_perm)
    );

    // R2
    flat_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_vld && !xlat_en) |=> (rsp_hit && rsp_ppn == $past(lk_vpn)));

    // R6
    pin_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_vld && xlat_en && pin_hit) |=> (rsp_hit && rsp_ppn == $past(pin_ppn)));

endmodule

// File: tb/tb_tlb_unified.sv
module tb_tlb_unified;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xlat_en = 1'b0;
    logic        lk_vld = 1'b0;
    logic [19:0] lk_vpn = '0;
    logic        rsp_vld, rsp_hit;
    logic [19:0] rsp_ppn;
    logic [3:0]  rsp_perm;
    logic        wr_en = 1'b0;
    logic [19:0] wr_vpn = '0, wr_ppn = '0;
    logic [3:0]  wr_perm = '0;
    logic        wr_pin = 1'b0;
    logic [2:0]  wr_slot = '0;
    logic        inv_all = 1'b0, inv_va = 1'b0;
    logic [19:0] inv_vpn = '0;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    tlb_unified dut (
        .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en),
        .lk_vld(lk_vld), .lk_vpn(lk_vpn),
        .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .rsp_perm(rsp_perm),
        .wr_en(wr_en), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn), .wr_perm(wr_perm),
        .wr_pin(wr_pin), .wr_slot(wr_slot),
        .inv_all(inv_all), .inv_va(inv_va), .inv_vpn(inv_vpn)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic lookup(input string req, input logic [19:0] v,
                          input logic h, input logic [19:0] p, input logic [3:0] pm);
        @(negedge clk);
        lk_vld = 1'b1; lk_vpn = v;
        @(negedge clk);
        lk_vld = 1'b0;
        chk({req, " vld"}, 32'(rsp_vld), 32'd1);
        chk({req, " hit"}, 32'(rsp_hit), 32'(h));
        chk({req, " ppn"}, 32'(rsp_ppn), 32'(p));
        chk({req, " perm"}, 32'(rsp_perm), 32'(pm));
    endtask

    task automatic write(input logic [19:0] v, input logic [19:0] p, input logic [3:0] pm,
                         input logic pin, input logic [2:0] slot);
        @(negedge clk);
        wr_en = 1'b1; wr_vpn = v; wr_ppn = p; wr_perm = pm; wr_pin = pin; wr_slot = slot;
        @(negedge clk);
        wr_en = 1'b0; wr_pin = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R3 idle after reset", 32'(rsp_vld), 32'd0);
        xlat_en = 1'b1;
        lookup("R1 empty", 20'h00003, 1'b0, 20'h0, 4'h0);
        lookup("R1 empty pinned page", 20'h12345, 1'b0, 20'h0, 4'h0);
        @(negedge clk);
        chk("R3 no request", 32'(rsp_vld), 32'd0);
    endtask

    task automatic t_flat();
        xlat_en = 1'b0;
        lookup("R2 flat", 20'hABCDE, 1'b1, 20'hABCDE, 4'hF);
        xlat_en = 1'b1;
    endtask

    task automatic t_set_fill();
        write(20'h00003, 20'h11111, 4'h5, 1'b0, 3'd0);
        lookup("R4 set hit", 20'h00003, 1'b1, 20'h11111, 4'h5);
        write(20'h00023, 20'h22222, 4'h6, 1'b0, 3'd0);
        write(20'h00043, 20'h33333, 4'h7, 1'b0, 3'd0);
        lookup("R10 first evicted", 20'h00003, 1'b0, 20'h0, 4'h0);
        lookup("R10 second kept", 20'h00023, 1'b1, 20'h22222, 4'h6);
        lookup("R10 third kept", 20'h00043, 1'b1, 20'h33333, 4'h7);
        write(20'h00004, 20'h44444, 4'h1, 1'b0, 3'd0);
        lookup("R10 other set", 20'h00004, 1'b1, 20'h44444, 4'h1);
        lookup("R10 other set leaves set 3", 20'h00043, 1'b1, 20'h33333, 4'h7);
    endtask

    task automatic t_rewrite();
        write(20'h00023, 20'h22220, 4'h2, 1'b0, 3'd0);
        lookup("R11 rewritten", 20'h00023, 1'b1, 20'h22220, 4'h2);
        lookup("R11 neighbour kept", 20'h00043, 1'b1, 20'h33333, 4'h7);
        write(20'h00063, 20'h66666, 4'h3, 1'b0, 3'd0);
        lookup("R11 pointer held", 20'h00043, 1'b1, 20'h33333, 4'h7);
        lookup("R11 pointer way evicted", 20'h00023, 1'b0, 20'h0, 4'h0);
    endtask

    task automatic t_pin();
        write(20'h12345, 20'h54321, 4'h3, 1'b1, 3'd2);
        lookup("R5 pinned hit", 20'h12345, 1'b1, 20'h54321, 4'h3);
        write(20'h00003, 20'h0AAAA, 4'h8, 1'b0, 3'd0);
        write(20'h00003, 20'h0BBBB, 4'h9, 1'b1, 3'd5);
        lookup("R6 pinned first", 20'h00003, 1'b1, 20'h0BBBB, 4'h9);
        write(20'h00003, 20'h0CCCC, 4'hA, 1'b1, 3'd6);
        lookup("R6 lowest slot", 20'h00003, 1'b1, 20'h0BBBB, 4'h9);
    endtask

    task automatic t_inv_all();
        @(negedge clk); inv_all = 1'b1;
        @(negedge clk); inv_all = 1'b0;
        lookup("R7 set cleared", 20'h00063, 1'b0, 20'h0, 4'h0);
        lookup("R7 set cleared other", 20'h00004, 1'b0, 20'h0, 4'h0);
        lookup("R7 pinned kept", 20'h12345, 1'b1, 20'h54321, 4'h3);
        lookup("R7 pinned kept 2", 20'h00003, 1'b1, 20'h0BBBB, 4'h9);
    endtask

    task automatic t_inv_va();
        write(20'h00003, 20'h0AAAA, 4'h8, 1'b0, 3'd0);
        write(20'h00025, 20'h25252, 4'h4, 1'b0, 3'd0);
        @(negedge clk); inv_va = 1'b1; inv_vpn = 20'h00003;
        @(negedge clk); inv_va = 1'b0;
        lookup("R8 both regions cleared", 20'h00003, 1'b0, 20'h0, 4'h0);
        lookup("R8 other pinned kept", 20'h12345, 1'b1, 20'h54321, 4'h3);
        lookup("R8 other set kept", 20'h00025, 1'b1, 20'h25252, 4'h4);
    endtask

    task automatic t_overwrite();
        write(20'h77777, 20'h70707, 4'hC, 1'b1, 3'd2);
        lookup("R9 old page gone", 20'h12345, 1'b0, 20'h0, 4'h0);
        lookup("R9 new page", 20'h77777, 1'b1, 20'h70707, 4'hC);
    endtask

    task automatic t_enable();
        xlat_en = 1'b0;
        lookup("R12 flat while off", 20'h77777, 1'b1, 20'h77777, 4'hF);
        xlat_en = 1'b1;
        lookup("R12 pinned back", 20'h77777, 1'b1, 20'h70707, 4'hC);
        lookup("R12 set back", 20'h00025, 1'b1, 20'h25252, 4'h4);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        inv_all = 1'b1;
        wr_en = 1'b1; wr_vpn = 20'h00026; wr_ppn = 20'h26262; wr_perm = 4'hD; wr_pin = 1'b0;
        @(negedge clk);
        inv_all = 1'b0; wr_en = 1'b0;
        lookup("R13 write survives clear", 20'h00026, 1'b1, 20'h26262, 4'hD);
        lookup("R13 clear applied", 20'h00025, 1'b0, 20'h0, 4'h0);
        @(negedge clk);
        inv_va = 1'b1; inv_vpn = 20'h77777;
        wr_en = 1'b1; wr_vpn = 20'h77777; wr_ppn = 20'h17171; wr_perm = 4'hE;
        wr_pin = 1'b1; wr_slot = 3'd2;
        @(negedge clk);
        inv_va = 1'b0; wr_en = 1'b0; wr_pin = 1'b0;
        lookup("R13 pinned write survives", 20'h77777, 1'b1, 20'h17171, 4'hE);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_flat();
        t_set_fill();
        t_rewrite();
        t_pin();
        t_inv_all();
        t_inv_va();
        t_overwrite();
        t_enable();
        t_same_cycle();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule